// File: doc/BRIEF.md
# Linear Sensor Readout Controller

This block sits on the host side of a 64-element linear photodiode sensor. From the system clock it generates the sensor clock and the frame start pulse. It schedules frames at a programmable integration interval. At a fixed delay after each pixel edge, once the analog output has settled, it asks an external ADC for one conversion. Each finished conversion is passed on as a stream word that carries the pixel index, the sample and an end-of-line flag.

Two configuration inputs set the timing: the sensor clock half period and the start-to-start interval, both counted in system clock cycles. Both values are sampled once per frame, in the cycle just before a new start pulse is raised. A value outside the legal range is clamped to the nearest legal value and sets a sticky error flag. After reset the controller runs one complete frame whose samples are discarded, because the sensor holds indeterminate charge at that point. Normal frames follow from then on.

Top module: `lin_scan_readout`

## Requirements
- R1: While reset is held, and in the first cycle after it, senClk, senStart, adcConvert, pixValid, pixLast and cfgErr are all low.
- R2: Inside a frame, each high phase and each low phase of senClk lasts halfEff system cycles. Every frame has exactly 65 rising edges, and the first of them is the edge that captures the start pulse.
- R3: senStart rises only while senClk is low, halfEff cycles before the capturing rising edge, and it falls in the same cycle as the following falling edge. It is therefore high across exactly one rising edge.
- R4: Consecutive capturing edges are exactly intEff system cycles apart.
- R5: adcConvert is a one-cycle pulse exactly SETTLE cycles after each of rising edges 1 to 64 of a frame. There are 64 pulses per frame, and none follows the 65th edge. senClk stays low between frames.
- R6: halfEff is cfgHalfDiv clamped to [MIN_HALF, MAX_HALF]. intEff is cfgIntPeriod clamped to [(64+2)*2*halfEff, MAX_INT]. Any clamp sets cfgErr, which then stays high until reset.
- R7: The first frame after reset produces no pixValid.
- R8: In every later frame, pixValid pulses once for each adcDone, one cycle after it. pixIndex carries 0 to 63 in conversion order, pixData carries the adcData value that came with adcDone, and pixLast is high only with index 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgHalfDiv | input | DIV_W | Requested sensor clock half period, system cycles |
| cfgIntPeriod | input | INT_W | Requested start-to-start interval, system cycles |
| adcDone | input | 1 | ADC result strobe |
| adcData | input | ADC_W | ADC result, valid with adcDone |
| senClk | output | 1 | Sensor clock |
| senStart | output | 1 | Sensor frame start pulse |
| adcConvert | output | 1 | ADC conversion request, one cycle |
| pixValid | output | 1 | Pixel sample valid |
| pixIndex | output | IDX_W | Pixel index, 0 to 63 |
| pixLast | output | 1 | High with the final pixel of a line |
| pixData | output | ADC_W | Pixel sample |
| cfgErr | output | 1 | Sticky flag: a configuration value was clamped |

## Verification
The assertions assume that the ADC answers each request with exactly one adcDone, and only while that request is still open. In other words, adcDone never comes without a preceding adcConvert, and it never comes after the next one. The bench ADC model replies a fixed three cycles after each request. That is shorter than any legal sensor clock period, so every answer lands before the next conversion. Configuration changes are applied away from both clock edges. The interval and phase checks are suspended for the three starts that follow a change, because the new values take effect only at a frame boundary.

// File: rtl/lin_scan_pkg.sv
package lin_scan_pkg;

  typedef enum logic [1:0] {
    S_LOAD = 2'd0,
    S_LEAD = 2'd1,
    S_RUN  = 2'd2,
    S_WAIT = 2'd3
  } scanStateT;

  typedef struct packed {
    logic clkHigh;
    logic startHigh;
    logic convert;
    logic flush;
  } scanStrobeT;

endpackage

// File: rtl/lin_scan_clamp.sv
module lin_scan_clamp #(
  parameter int NUM_PIX  = 64,
  parameter int DIV_W    = 16,
  parameter int INT_W    = 24,
  parameter int MIN_HALF = 10,
  parameter int MAX_HALF = 10000,
  parameter int MAX_INT  = 10000000
) (
  input  logic [DIV_W-1:0] reqHalf,
  input  logic [INT_W-1:0] reqInt,
  output logic [DIV_W-1:0] halfEff,
  output logic [INT_W-1:0] intEff,
  output logic             clampHit
);
  localparam int PW = INT_W + DIV_W + 8;

  logic [PW-1:0] minInt;
  logic          halfLow, halfHigh, intLow, intHigh;

  always_comb begin
    halfLow  = reqHalf < DIV_W'(MIN_HALF);
    halfHigh = reqHalf > DIV_W'(MAX_HALF);
    if (halfLow)       halfEff = DIV_W'(MIN_HALF);
    else if (halfHigh) halfEff = DIV_W'(MAX_HALF);
    else               halfEff = reqHalf;
    // frame of 65 edges plus one idle period before the next capture
    minInt  = PW'(NUM_PIX + 2) * PW'(halfEff) * PW'(2);
    intLow  = PW'(reqInt) < minInt;
    intHigh = reqInt > INT_W'(MAX_INT);
    if (intLow)       intEff = INT_W'(minInt);
    else if (intHigh) intEff = INT_W'(MAX_INT);
    else              intEff = reqInt;
    clampHit = halfLow | halfHigh | intLow | intHigh;
  end
endmodule

// File: rtl/lin_scan_ctrl.sv
module lin_scan_ctrl
  import lin_scan_pkg::*;
#(
  parameter int NUM_PIX  = 64,
  parameter int IDX_W    = 6,
  parameter int DIV_W    = 16,
  parameter int INT_W    = 24,
  parameter int MIN_HALF = 10,
  parameter int MAX_HALF = 10000,
  parameter int SETTLE   = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfEff,
  input  logic [INT_W-1:0] intEff,
  input  logic             clampHit,
  output scanStrobeT       strb,
  output logic [IDX_W-1:0] pixIdx,
  output logic             cfgErr
);
  scanStateT          state;
  logic [DIV_W-1:0]   halfQ;
  logic [INT_W-1:0]   intQ;
  logic [DIV_W:0]     phCnt;
  logic [DIV_W:0]     periodLen;
  logic [IDX_W:0]     edgeCnt;
  logic [INT_W-1:0]   tCnt;
  logic [INT_W-1:0]   loadAt;
  logic               flushQ;
  logic               inHigh;

  assign periodLen = {halfQ, 1'b0};
  assign loadAt    = intQ - INT_W'(halfQ) - INT_W'(2);
  assign inHigh    = phCnt < {1'b0, halfQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_LOAD;
      halfQ   <= DIV_W'(MIN_HALF);
      intQ    <= '0;
      phCnt   <= '0;
      edgeCnt <= '0;
      tCnt    <= '0;
      flushQ  <= 1'b1;
      cfgErr  <= 1'b0;
    end else begin
      unique case (state)
        S_LOAD: begin
          halfQ <= halfEff;
          intQ  <= intEff;
          if (clampHit) cfgErr <= 1'b1;
          phCnt <= '0;
          tCnt  <= tCnt + 1'b1;
          state <= S_LEAD;
        end
        S_LEAD: begin
          if (phCnt == {1'b0, halfQ} - 1'b1) begin
            phCnt   <= '0;
            edgeCnt <= '0;
            tCnt    <= '0;
            state   <= S_RUN;
          end else begin
            phCnt <= phCnt + 1'b1;
            tCnt  <= tCnt + 1'b1;
          end
        end
        S_RUN: begin
          tCnt <= tCnt + 1'b1;
          if (phCnt == periodLen - 1'b1) begin
            phCnt <= '0;
            if (edgeCnt == (IDX_W+1)'(NUM_PIX)) begin
              state  <= S_WAIT;
              flushQ <= 1'b0;
            end else begin
              edgeCnt <= edgeCnt + 1'b1;
            end
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        S_WAIT: begin
          tCnt <= tCnt + 1'b1;
          if (tCnt >= loadAt) state <= S_LOAD;
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  always_comb begin
    strb.clkHigh   = (state == S_RUN) && inHigh;
    strb.startHigh = (state == S_LEAD) ||
                     ((state == S_RUN) && (edgeCnt == '0) && inHigh);
    strb.convert   = (state == S_RUN) && (edgeCnt < (IDX_W+1)'(NUM_PIX)) &&
                     (phCnt == (DIV_W+1)'(SETTLE));
    strb.flush     = flushQ;
    pixIdx         = edgeCnt[IDX_W-1:0];
  end

  // R2: the edge counter never passes the terminating edge
  a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= (IDX_W+1)'(NUM_PIX));

  // R6: the latched half period always lies in the legal range
  a_r6_half_range: assert property (@(posedge clk) disable iff (!rstN)
    (halfQ >= DIV_W'(MIN_HALF)) && (halfQ <= DIV_W'(MAX_HALF)));

  // R6: the error flag never clears without reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

// File: rtl/lin_scan_dpath.sv
module lin_scan_dpath
  import lin_scan_pkg::*;
#(
  parameter int NUM_PIX = 64,
  parameter int IDX_W   = 6,
  parameter int ADC_W   = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobeT       strb,
  input  logic [IDX_W-1:0] pixIdxIn,
  input  logic             adcDone,
  input  logic [ADC_W-1:0] adcData,
  output logic             senClk,
  output logic             senStart,
  output logic             adcConvert,
  output logic             pixValid,
  output logic [IDX_W-1:0] pixIndex,
  output logic             pixLast,
  output logic [ADC_W-1:0] pixData
);
  logic             pendBusy;
  logic             pendFlush;
  logic [IDX_W-1:0] pendIdx;
  logic             accept;

  assign accept = adcDone && pendBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senClk     <= 1'b0;
      senStart   <= 1'b0;
      adcConvert <= 1'b0;
      pendBusy   <= 1'b0;
      pendFlush  <= 1'b0;
      pendIdx    <= '0;
      pixValid   <= 1'b0;
      pixIndex   <= '0;
      pixLast    <= 1'b0;
      pixData    <= '0;
    end else begin
      senClk     <= strb.clkHigh;
      senStart   <= strb.startHigh;
      adcConvert <= strb.convert;
      if (strb.convert) begin
        pendBusy  <= 1'b1;
        pendIdx   <= pixIdxIn;
        pendFlush <= strb.flush;
      end else if (accept) begin
        pendBusy <= 1'b0;
      end
      pixValid <= accept && !pendFlush;
      pixLast  <= accept && !pendFlush && (pendIdx == IDX_W'(NUM_PIX - 1));
      if (accept) begin
        pixIndex <= pendIdx;
        pixData  <= adcData;
      end
    end
  end

  // R3: a start pulse is never raised while the sensor clock is high
  a_r3_start_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(senStart) |-> !senClk);

  // R5: each conversion request lasts a single cycle
  a_r5_conv_single: assert property (@(posedge clk) disable iff (!rstN)
    adcConvert |=> !adcConvert);

  // R8: input rule, a result only arrives for an open request
  a_r8_done_pending: assert property (@(posedge clk) disable iff (!rstN)
    adcDone |-> pendBusy);

  // R8: the end-of-line flag only rides on the final valid pixel
  a_r8_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    pixLast |-> (pixValid && (pixIndex == IDX_W'(NUM_PIX - 1))));
endmodule

// File: rtl/lin_scan_readout.sv
module lin_scan_readout
  import lin_scan_pkg::*;
#(
  parameter int NUM_PIX  = 64,
  parameter int IDX_W    = $clog2(NUM_PIX),
  parameter int ADC_W    = 12,
  parameter int DIV_W    = 16,
  parameter int INT_W    = 24,
  parameter int MIN_HALF = 10,
  parameter int MAX_HALF = 10000,
  parameter int MAX_INT  = 10000000,
  parameter int SETTLE   = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic [INT_W-1:0] cfgIntPeriod,
  input  logic             adcDone,
  input  logic [ADC_W-1:0] adcData,
  output logic             senClk,
  output logic             senStart,
  output logic             adcConvert,
  output logic             pixValid,
  output logic [IDX_W-1:0] pixIndex,
  output logic             pixLast,
  output logic [ADC_W-1:0] pixData,
  output logic             cfgErr
);
  logic [DIV_W-1:0] halfEff;
  logic [INT_W-1:0] intEff;
  logic             clampHit;
  scanStrobeT       strb;
  logic [IDX_W-1:0] pixIdx;

  lin_scan_clamp #(
    .NUM_PIX(NUM_PIX), .DIV_W(DIV_W), .INT_W(INT_W),
    .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF), .MAX_INT(MAX_INT)
  ) uClamp (
    .reqHalf(cfgHalfDiv), .reqInt(cfgIntPeriod),
    .halfEff(halfEff), .intEff(intEff), .clampHit(clampHit)
  );

  lin_scan_ctrl #(
    .NUM_PIX(NUM_PIX), .IDX_W(IDX_W), .DIV_W(DIV_W), .INT_W(INT_W),
    .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF), .SETTLE(SETTLE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .halfEff(halfEff), .intEff(intEff),
    .clampHit(clampHit), .strb(strb), .pixIdx(pixIdx), .cfgErr(cfgErr)
  );

  lin_scan_dpath #(
    .NUM_PIX(NUM_PIX), .IDX_W(IDX_W), .ADC_W(ADC_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIdxIn(pixIdx),
    .adcDone(adcDone), .adcData(adcData),
    .senClk(senClk), .senStart(senStart), .adcConvert(adcConvert),
    .pixValid(pixValid), .pixIndex(pixIndex), .pixLast(pixLast),
    .pixData(pixData)
  );
endmodule

// File: tb/sim_lin_scan_readout.sv
module sim_lin_scan_readout;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX       = 64;
  localparam int ADC_W      = 12;
  localparam int DIV_W      = 16;
  localparam int INT_W      = 24;
  localparam int MIN_HALF   = 10;
  localparam int MAX_HALF   = 20;
  localparam int MAX_INT    = 3000;
  localparam int SETTLE     = 19;
  localparam int ADC_LAT    = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] cfgHalfDiv = '0;
  logic [INT_W-1:0] cfgIntPeriod = '0;
  logic             adcDone = 1'b0;
  logic [ADC_W-1:0] adcData = '0;
  logic             senClk, senStart, adcConvert, pixValid, pixLast, cfgErr;
  logic [5:0]       pixIndex;
  logic [ADC_W-1:0] pixData;

  lin_scan_readout #(
    .NUM_PIX(NPIX), .ADC_W(ADC_W), .DIV_W(DIV_W), .INT_W(INT_W),
    .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF), .MAX_INT(MAX_INT),
    .SETTLE(SETTLE)
  ) u0 (
    .clk(clk), .rstN(rstN), .cfgHalfDiv(cfgHalfDiv), .cfgIntPeriod(cfgIntPeriod),
    .adcDone(adcDone), .adcData(adcData), .senClk(senClk), .senStart(senStart),
    .adcConvert(adcConvert), .pixValid(pixValid), .pixIndex(pixIndex),
    .pixLast(pixLast), .pixData(pixData), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int idx; int data; } itemT;
  itemT expQ[$];

  int checks = 0, fails = 0;
  int cyc = 0;
  int expHalf = 10, expInt = 1500, skip = 0;
  int frameNo = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int sampleVal(int fr, int idx);
    return ((fr * 37 + idx * 5) ^ 'h2A5) & 'hFFF;
  endfunction

  // driver: answers a conversion and pushes the expected stream item
  int adcCount = 0, adcIdx = 0;
  task automatic adcRequest(int idx);
    itemT it;
    adcCount = ADC_LAT;
    adcIdx   = idx;
    if (frameNo >= 2) begin
      it.idx  = idx;
      it.data = sampleVal(frameNo, idx);
      expQ.push_back(it);
    end
  endtask

  // monitor: pin timing and scoreboard compare, sampled at the falling edge
  initial begin
    int lastRise = 0, lastFall = 0, lastStart = 0, startRise = 0;
    int edges = 0, convCnt = 0, validCnt = 0;
    bit prevClk = 0, prevStart = 0;
    itemT got;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rstN) begin
        frameNo = 0; edges = 0; convCnt = 0; validCnt = 0;
        adcCount = 0; adcDone = 1'b0; expQ.delete();
        prevClk = 0; prevStart = 0;
        continue;
      end
      if (senStart && !prevStart) begin
        chk("R3 start rises with clock low", int'(senClk), 0);
        startRise = cyc;
      end
      if (senClk && !prevClk) begin
        if (senStart) begin
          if (frameNo > 0) begin
            chk("R2 rising edges per frame", edges, NPIX + 1);
            chk("R5 conversions per frame", convCnt, NPIX);
            if (skip == 0) chk("R4 start interval", cyc - lastStart, expInt);
            if (frameNo == 1) chk("R7 flush frame valids", validCnt, 0);
            else chk("R8 valids per frame", validCnt, NPIX);
          end
          if (skip == 0) chk("R3 start setup", cyc - startRise, expHalf);
          frameNo++;
          if (skip > 0) skip--;
          edges = 1; convCnt = 0; validCnt = 0; lastStart = cyc;
        end else begin
          edges++;
          if (skip == 0) chk("R2 low phase", cyc - lastFall, expHalf);
        end
        lastRise = cyc;
      end
      if (!senClk && prevClk) begin
        if (skip == 0) chk("R2 high phase", cyc - lastRise, expHalf);
        if (edges == 1) chk("R3 start falls with clock", int'(senStart), 0);
        lastFall = cyc;
      end
      adcDone = 1'b0;
      if (adcCount > 0) begin
        adcCount--;
        if (adcCount == 0) begin
          adcDone = 1'b1;
          adcData = ADC_W'(sampleVal(frameNo, adcIdx));
        end
      end
      if (adcConvert) begin
        chk("R5 settle delay", cyc - lastRise, SETTLE);
        if (convCnt >= NPIX) chk("R5 no conversion on terminating edge", convCnt, NPIX - 1);
        adcRequest(convCnt);
        convCnt++;
      end
      if (pixValid) begin
        validCnt++;
        if (expQ.size() == 0) begin
          chk("R7 unexpected pixel valid", 1, 0);
        end else begin
          got = expQ.pop_front();
          chk("R8 pixel index", int'(pixIndex), got.idx);
          chk("R8 pixel data", int'(pixData), got.data);
          chk("R8 last flag", int'(pixLast), (got.idx == NPIX - 1) ? 1 : 0);
        end
      end
      prevClk = senClk;
      prevStart = senStart;
    end
  end

  task automatic waitFrames(int n);
    int target = frameNo + n;
    while (frameNo < target) @(negedge clk);
  endtask

  task automatic setCfg(int h, int i, int eh, int ei);
    @(posedge clk); #1;
    cfgHalfDiv = DIV_W'(h);
    cfgIntPeriod = INT_W'(i);
    expHalf = eh;
    expInt = ei;
    skip = 3;
  endtask

  task automatic checkResetPins();
    chk("R1 senClk in reset", int'(senClk), 0);
    chk("R1 senStart in reset", int'(senStart), 0);
    chk("R1 adcConvert in reset", int'(adcConvert), 0);
    chk("R1 pixValid in reset", int'(pixValid), 0);
    chk("R1 pixLast in reset", int'(pixLast), 0);
    chk("R1 cfgErr in reset", int'(cfgErr), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    cfgHalfDiv = 16'd10;
    cfgIntPeriod = 24'd1500;
    expHalf = 10; expInt = 1500; skip = 0;
    repeat (5) @(negedge clk);
    checkResetPins();
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    checkResetPins();
    waitFrames(4);
    chk("R6 no error for legal values", int'(cfgErr), 0);

    setCfg(15, 2200, 15, 2200);
    waitFrames(5);
    chk("R6 no error for legal values", int'(cfgErr), 0);

    setCfg(3, 100, 10, 1320);
    waitFrames(5);
    chk("R6 error after low clamp", int'(cfgErr), 1);

    setCfg(50, 5000, 20, 3000);
    waitFrames(5);
    chk("R6 error after high clamp", int'(cfgErr), 1);

    setCfg(10, 1500, 10, 1500);
    waitFrames(4);
    chk("R6 error stays sticky", int'(cfgErr), 1);

    @(posedge clk); #1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkResetPins();
    skip = 0;
    @(posedge clk); #1;
    rstN = 1'b1;
    waitFrames(3);
    chk("R8 scoreboard drained", expQ.size(), 0);
    chk("R6 error cleared by reset", int'(cfgErr), 0);
    finish();
  end
endmodule